// File: doc/BRIEF.md
# Arrival-Order Bus Arbiter

This block shares one bus among four requesters. No requester has a built-in rank: whoever asks first is served first. A requester pulls its active-low request line low and waits for the matching active-low grant line. It keeps the request low for as long as it uses the bus, then releases it. Requests that show up while the bus is busy wait in an ordered queue. The queue drops a waiting requester that gives up before it is served.

The design runs on a system clock. Every request line passes through a two-flop synchronizer. Arrival order is taken from the clock cycle in which each synchronized request first appears. When several requests appear in the same cycle, a free-running 8-bit LFSR picks one of them to go first. The others queue behind the pick in ascending index order, and no new grant is issued during the one cycle the choice takes. An active-low enable masks every grant output without stopping the arbitration behind it.

Top module: `fcfs_arbiter`

## Requirements
- R1: Request and grant pins are active low. Grant bit n answers request bit n, and after reset every grant pin is high.
- R2: On an idle arbiter, a lone request that is first sampled low at rising edge k drives its grant low after edge k+3. A holder that releases its request before edge m sees its grant go high after edge m+2.
- R3: While the enable input is high, every grant pin is high. Queueing and hand-over continue, so the current holder shows up as soon as enable returns low.
- R4: Requests that arrive in different cycles are granted in the order they arrived, whatever their indices.
- R5: When the holder releases, the next queued requester is granted exactly one cycle after the old grant goes high. A grant never passes directly from one line to another.
- R6: If two or more requests arrive in the same cycle, exactly one of them is granted first, and one cycle later than a lone arrival would be. The rest are then served in ascending index order.
- R7: A queued request that is withdrawn before it is granted leaves the queue and is never granted. The other entries keep their relative order.
- R8: A request line held high is never granted.
- R9: At most one grant pin is low at any time.
- R10: The holder keeps its grant for as long as its request stays low, even while other requests wait.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_n | input | N_REQ | Request lines, active low, one per requester |
| en_n | input | 1 | Grant enable, active low; high forces every grant high |
| gnt_n | output | N_REQ | Grant lines, active low, bit n answering request n |

## Verification
Two things can land on the same clock edge. A new arrival can be appended to the queue while the holder's release removes the holder and a queued entry's withdrawal removes that entry. A tie among simultaneous arrivals can also resolve at the same edge as a hand-over. The bench provokes these by:
- driving several request lines low on one falling edge;
- withdrawing a waiting line while the holder still owns the bus;
- releasing the holder while the enable masks the outputs.

It then judges the grant order seen at the pins against the arrival sequence it drove. It accepts any winner of a tie from the tied set, and checks that the remaining tied lines follow in ascending order.

// File: rtl/fcfs_pkg.sv
// Package: fcfs_pkg
// Shared constants for the arrival-order arbiter: the default requester
// count and the random-source shape. Assumes a Galois right-shift LFSR,
// for which the tap mask below gives a maximal-length sequence.
package fcfs_pkg;
    localparam int DEF_REQS   = 4;
    localparam int RND_W      = 8;
    localparam logic [RND_W-1:0] RND_TAPS = 8'hB8;
    localparam logic [RND_W-1:0] RND_SEED = 8'h5A;
endpackage

// File: rtl/fcfs_sync.sv
// Module: fcfs_sync
// Brings each active-low request line into the clock domain through a
// chain of STAGES flops. The output is active high.
// Assumes: each line is independent; reset clears the chain to "no request".
module fcfs_sync #(
    parameter int N      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_n,
    output logic [N-1:0] req_s
);
    logic [N-1:0] chain [STAGES];

    // Shift the inverted request lines through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= '0;
        end else begin
            chain[0] <= ~req_n;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign req_s = chain[STAGES-1];
endmodule

// File: rtl/fcfs_lfsr.sv
// Module: fcfs_lfsr
// Free-running Galois LFSR used only as a tie-break source.
// Assumes: SEED is nonzero, so the register never locks up at zero.
module fcfs_lfsr #(
    parameter int           W    = 8,
    parameter logic [W-1:0] TAPS = 8'hB8,
    parameter logic [W-1:0] SEED = 8'h5A
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] rnd
);
    // Advance the sequence once per clock.
    always_ff @(posedge clk) begin
        if (!rst_n)      rnd <= SEED;
        else if (rnd[0]) rnd <= (rnd >> 1) ^ TAPS;
        else             rnd <= rnd >> 1;
    end
endmodule

// File: rtl/fcfs_queue.sv
// Module: fcfs_queue
// Ordered list of requester indices, oldest first. On each clock it:
//   1. drops entries whose synchronized request is no longer live,
//      closing the gaps while keeping their order;
//   2. appends the new arrivals, with the random winner first and the
//      other arrivals after it in ascending index order.
// Assumes: an arriving index is never already queued (it was not live
// in the previous cycle, so it was dropped then), so N slots suffice.
module fcfs_queue #(
    parameter int N  = 4,
    parameter int IW = 2,
    parameter int LW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  live,
    input  logic [N-1:0]  arrive,
    input  logic [LW-1:0] rnd,
    output logic [IW-1:0] head_idx,
    output logic          head_vld
);
    logic [IW-1:0] q_idx [N];
    logic [N-1:0]  q_vld;
    logic [IW-1:0] n_idx [N];
    logic [N-1:0]  n_vld;
    logic [IW-1:0] start;
    logic [IW-1:0] win;
    logic          win_vld;

    // Map the random word onto a starting index for the circular search.
    assign start = IW'(int'(rnd) % N);

    // Pick the first arrival found at or after the random start, wrapping.
    always_comb begin
        win     = '0;
        win_vld = 1'b0;
        for (int j = 0; j < N; j++) begin
            if (!win_vld && arrive[IW'((int'(start) + j) % N)]) begin
                win     = IW'((int'(start) + j) % N);
                win_vld = 1'b1;
            end
        end
    end

    // Build the next queue: surviving entries in order, then the arrivals.
    always_comb begin
        int fill;
        fill  = 0;
        n_vld = '0;
        for (int i = 0; i < N; i++) n_idx[i] = '0;
        for (int i = 0; i < N; i++) begin
            if (q_vld[i] && live[q_idx[i]]) begin
                n_idx[IW'(fill)] = q_idx[i];
                n_vld[IW'(fill)] = 1'b1;
                fill++;
            end
        end
        if (win_vld && fill < N) begin
            n_idx[IW'(fill)] = win;
            n_vld[IW'(fill)] = 1'b1;
            fill++;
        end
        for (int i = 0; i < N; i++) begin
            if (arrive[i] && IW'(i) != win && fill < N) begin
                n_idx[IW'(fill)] = IW'(i);
                n_vld[IW'(fill)] = 1'b1;
                fill++;
            end
        end
    end

    // Load the rebuilt queue each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_vld <= '0;
            for (int i = 0; i < N; i++) q_idx[i] <= '0;
        end else begin
            q_vld <= n_vld;
            for (int i = 0; i < N; i++) q_idx[i] <= n_idx[i];
        end
    end

    assign head_idx = q_idx[0];
    assign head_vld = q_vld[0];
endmodule

// File: rtl/fcfs_arbiter.sv
// Module: fcfs_arbiter (top)
// Arrival-order arbiter for N_REQ requesters.
//   - Requests are synchronized, and a new arrival is a synchronized
//     request that was not live in the previous cycle.
//   - The queue holds arrival order; the grant register serves its head.
//   - Once released, a grant stays idle for one cycle before the next.
//   - A multi-arrival cycle blocks new grants for one extra cycle.
//   - en_n masks the grant pins only; the arbitration keeps running.
// Assumes: N_REQ is a power of two, at least 2.
module fcfs_arbiter
    import fcfs_pkg::*;
#(
    parameter int N_REQ       = DEF_REQS,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_REQ-1:0] req_n,
    input  logic             en_n,
    output logic [N_REQ-1:0] gnt_n
);
    localparam int IW = $clog2(N_REQ);

    logic [N_REQ-1:0] req_s;
    logic [N_REQ-1:0] req_d;
    logic [N_REQ-1:0] arrive;
    logic [RND_W-1:0] rnd;
    logic [IW-1:0]    head_idx;
    logic             head_vld;
    logic [IW-1:0]    gnt_idx;
    logic             gnt_vld;
    logic             tie_gap;
    logic [N_REQ-1:0] gnt_q;

    fcfs_sync #(.N(N_REQ), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .req_n (req_n),
        .req_s (req_s)
    );

    fcfs_lfsr #(.W(RND_W), .TAPS(RND_TAPS), .SEED(RND_SEED)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .rnd   (rnd)
    );

    // New arrivals are requests that were not live in the previous cycle.
    assign arrive = req_s & ~req_d;

    fcfs_queue #(.N(N_REQ), .IW(IW), .LW(RND_W)) u_queue (
        .clk      (clk),
        .rst_n    (rst_n),
        .live     (req_s),
        .arrive   (arrive),
        .rnd      (rnd),
        .head_idx (head_idx),
        .head_vld (head_vld)
    );

    // Keep the previous requests, flag tie cycles, and move the grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_d   <= '0;
            tie_gap <= 1'b0;
            gnt_vld <= 1'b0;
            gnt_idx <= '0;
        end else begin
            req_d   <= req_s;
            tie_gap <= ($countones(arrive) > 1);
            if (gnt_vld) begin
                if (!req_s[gnt_idx]) gnt_vld <= 1'b0;
            end else if (head_vld && req_s[head_idx] && !tie_gap) begin
                gnt_vld <= 1'b1;
                gnt_idx <= head_idx;
            end
        end
    end

    // Decode the held grant into one line per requester.
    always_comb begin
        for (int i = 0; i < N_REQ; i++) gnt_q[i] = gnt_vld && (gnt_idx == IW'(i));
    end

    // Drive active-low pins, all forced high while the enable is inactive.
    assign gnt_n = ~(gnt_q & {N_REQ{~en_n}});
endmodule

// File: rtl/fcfs_arbiter_chk.sv
// Module: fcfs_arbiter_chk
// Property checker for fcfs_arbiter, attached with the bind below.
// Assumes: probes the decoded grant register, the queue head, the
// synchronized requests and the tie flag of the arbiter.
module fcfs_arbiter_chk #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic [N-1:0]  gnt_q,
    input logic [IW-1:0] gnt_idx,
    input logic [IW-1:0] head_idx,
    input logic          head_vld,
    input logic [N-1:0]  req_s,
    input logic          tie_gap
);
    // R9: never more than one grant held
    a_r9_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_q));

    // R5: no direct hand-over between two lines
    a_r5_no_direct_handover: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(gnt_q) != '0 && gnt_q != '0) |-> gnt_q == $past(gnt_q));

    // R10: the holder keeps the grant while its request is live
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_q != '0 && (gnt_q & req_s) == gnt_q) |=> gnt_q == $past(gnt_q));

    // R2: a released holder loses the grant on the next edge
    a_r2_release: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_q != '0 && (gnt_q & ~req_s) != '0) |=> gnt_q == '0);

    // R6: no new grant while a tie is being resolved
    a_r6_tie_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (tie_gap && gnt_q == '0) |=> gnt_q == '0);

    // R4: a new grant goes to the previous queue head, which was requesting
    a_r4_grant_head: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_q & ~$past(gnt_q)) != '0 |->
            ($past(head_vld) && gnt_idx == $past(head_idx) && (gnt_q & $past(req_s)) == gnt_q));
endmodule

bind fcfs_arbiter fcfs_arbiter_chk #(.N(N_REQ), .IW(IW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .gnt_q    (gnt_q),
    .gnt_idx  (gnt_idx),
    .head_idx (head_idx),
    .head_vld (head_vld),
    .req_s    (req_s),
    .tie_gap  (tie_gap)
);

// File: tb/tb_fcfs_arbiter.sv
// Directed bench for fcfs_arbiter: one task per scenario, each checking itself.
// Inputs change on falling edges and outputs are sampled on falling edges.
module tb_fcfs_arbiter;
    localparam int CLK_PERIOD = 10;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req_n = '1;
    logic         en_n = 1'b0;
    logic [N-1:0] gnt_n;
    int n_chk = 0;
    int n_bad = 0;
    int multi = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fcfs_arbiter #(.N_REQ(N)) dut (
        .clk   (clk),
        .rst_n (rst_n),
        .req_n (req_n),
        .en_n  (en_n),
        .gnt_n (gnt_n)
    );

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cyc(int k);
        repeat (k) @(negedge clk);
    endtask

    function automatic logic [N-1:0] pin(int i);
        return ~(N'(1) << i);
    endfunction

    // R9 monitor: count cycles with more than one grant low
    always @(negedge clk) if (rst_n && $countones(~gnt_n) > 1) multi++;

    task automatic t_single();
        req_n[2] = 1'b0;
        cyc(3); check("R2 no grant before latency", gnt_n, 4'hF);
        cyc(1); check("R1 R2 grant on line 2", gnt_n, pin(2));
        req_n[2] = 1'b1;
        cyc(2); check("R10 grant held until release seen", gnt_n, pin(2));
        cyc(1); check("R2 grant dropped after release", gnt_n, 4'hF);
        cyc(4);
    endtask

    task automatic t_order();
        req_n[3] = 1'b0; cyc(1);
        req_n[1] = 1'b0; cyc(1);
        req_n[0] = 1'b0; cyc(2);
        check("R4 first arrival granted", gnt_n, pin(3));
        cyc(6); check("R10 holder keeps bus", gnt_n, pin(3));
        req_n[3] = 1'b1;
        cyc(3); check("R5 idle cycle after release", gnt_n, 4'hF);
        cyc(1); check("R4 second arrival next", gnt_n, pin(1));
        req_n[1] = 1'b1;
        cyc(3); check("R5 idle cycle after second", gnt_n, 4'hF);
        cyc(1); check("R4 third arrival last", gnt_n, pin(0));
        req_n[0] = 1'b1;
        cyc(5); check("R2 all released", gnt_n, 4'hF);
    endtask

    task automatic t_tie();
        logic [N-1:0] g, rem;
        int first, second;
        req_n = 4'b0001;
        cyc(4); check("R6 tie gap holds grants off", gnt_n, 4'hF);
        cyc(1);
        g = ~gnt_n;
        check("R6 one winner from tied set",
              int'($countones(g) == 1 && (g & 4'b0001) == 4'b0000), 1);
        rem = 4'b1110 & ~g;
        first = -1; second = -1;
        for (int i = 0; i < N; i++) if (rem[i]) begin
            if (first < 0) first = i; else second = i;
        end
        req_n = req_n | g;
        cyc(4);
        if (first >= 0) check("R6 lower loser next", gnt_n, pin(first));
        if (first >= 0) req_n[first] = 1'b1;
        cyc(4);
        if (second >= 0) check("R6 higher loser last", gnt_n, pin(second));
        req_n = '1;
        cyc(5);
    endtask

    task automatic t_enable();
        req_n[0] = 1'b0;
        cyc(4); check("R3 grant visible with enable low", gnt_n, pin(0));
        en_n = 1'b1; req_n[2] = 1'b0;
        #1; check("R3 enable high masks grant", gnt_n, 4'hF);
        cyc(4);
        req_n[0] = 1'b1;
        cyc(5); check("R3 still masked after hand-over", gnt_n, 4'hF);
        en_n = 1'b0;
        #1; check("R3 hand-over happened behind mask", gnt_n, pin(2));
        req_n[2] = 1'b1;
        cyc(5);
    endtask

    task automatic t_withdraw();
        req_n[0] = 1'b0; cyc(1);
        req_n[1] = 1'b0; cyc(1);
        req_n[2] = 1'b0; cyc(1);
        req_n[3] = 1'b0; cyc(1);
        check("R7 first requester holds", gnt_n, pin(0));
        req_n[2] = 1'b1;
        cyc(4); check("R7 withdrawal leaves holder alone", gnt_n, pin(0));
        req_n[0] = 1'b1;
        cyc(4); check("R7 order kept for line 1", gnt_n, pin(1));
        req_n[1] = 1'b1;
        cyc(4); check("R7 withdrawn line 2 skipped", gnt_n, pin(3));
        req_n[3] = 1'b1;
        cyc(5);
    endtask

    task automatic t_unused();
        int low3, seen;
        low3 = 0; seen = 0;
        req_n[0] = 1'b0; cyc(1);
        req_n[1] = 1'b0;
        for (int c = 0; c < 24; c++) begin
            cyc(1);
            if (!gnt_n[3]) low3++;
            if (gnt_n != 4'hF) seen++;
            if (c == 8) req_n[0] = 1'b1;
            if (c == 16) req_n[1] = 1'b1;
        end
        check("R8 idle line 3 never granted", low3, 0);
        check("R8 other lines were served", int'(seen > 0), 1);
        cyc(4);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        cyc(4);
        rst_n = 1'b1;
        cyc(1);
        check("R1 reset leaves grants high", gnt_n, 4'hF);
        t_single();
        t_order();
        t_tie();
        t_enable();
        t_withdraw();
        t_unused();
        check("R9 never two grants", multi, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule